// File: doc/BRIEF.md
# Prioritized Pending Interrupt Arbiter

This block keeps one pending flag for each of twelve asynchronous interrupt sources of a processor core. Each cycle it picks at most one source to deliver. Sources are ranked in a fixed order. The two highest-ranked sources are never masked. One source is gated by a critical-enable input, and the remaining nine are gated by an external-enable input. The chosen source comes out as a registered 4-bit code with a take strobe. A registered hard-request line tells the core that some flag is still set.

Most sources are edge-type: a one-cycle pulse on their set line raises the flag, and delivery lowers it. The external and critical-external sources are level-type: their flags follow their input lines, and delivery leaves them alone. The decrementer flag is lowered on delivery only when a configuration input asks for it. The two doorbell flags can also be raised and lowered by message operations. A send is accepted when it is broadcast or when its tag matches this core's identifier. A clear needs no tag match.

Top module: `irq_arbiter`

## Requirements
- R1: Codes follow the priority rank, lowest code first: 0 system reset, 1 machine check, 2 critical external, 3 watchdog, 4 critical doorbell, 5 fixed-interval timer, 6 programmable-interval timer, 7 decrementer, 8 external, 9 doorbell, 10 performance monitor, 11 thermal. Codes 0 and 1 are never masked, and code 0 wins over code 1.
- R2: Code 2 is eligible only while `crit_en_i` is 1. `ext_en_i` has no effect on it.
- R3: Codes 3 to 11 are eligible only while `ext_en_i` is 1. Among eligible sources the lowest code wins.
- R4: Bit k of `pending_o` is the flag for code k. `take_o` and `code_o` are registered from the flags shown on `pending_o` and from the enables sampled at the same clock edge. This puts them one cycle behind the flag. When nothing is eligible, `take_o` is 0 and `code_o` is 0.
- R5: Edge-type flags (all except codes 2, 8 and 7) are set by a pulse on `src_set_i[k]` and cleared at the edge where they are delivered. A set that arrives at that same edge wins.
- R6: The level-type flags (codes 2 and 8) equal `src_set_i[k]` one cycle later. Delivery never clears them.
- R7: The decrementer flag (code 7) is cleared on delivery only when `decr_cod_i` is 1 at that edge. Otherwise it stays set.
- R8: `hard_req_o` is 1 exactly while `pending_o` is non-zero. It drops in the same cycle the last flag clears.
- R9: Message type 0 selects the doorbell flag (code 9) and type 1 selects the critical doorbell flag (code 4). Any other type leaves every flag unchanged.
- R10: A send (`msg_valid_i`=1, `msg_clr_i`=0) sets the selected flag when `msg_bcast_i` is 1 or when `msg_tag_i` equals `core_id_i`. Otherwise it has no effect.
- R11: A clear (`msg_valid_i`=1, `msg_clr_i`=1) clears the selected flag whatever the tag is, and leaves the other doorbell flag alone.
- R12: A synchronous active-high `rst` clears all flags, `take_o`, `code_o` and `hard_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_set_i | input | 12 | Per-source set pulse (edge type) or level (codes 2, 8) |
| crit_en_i | input | 1 | Critical-enable gate for code 2 |
| ext_en_i | input | 1 | External-enable gate for codes 3 to 11 |
| decr_cod_i | input | 1 | Decrementer clear-on-delivery configuration |
| msg_valid_i | input | 1 | Doorbell message operation valid |
| msg_clr_i | input | 1 | 1 = clear operation, 0 = send |
| msg_type_i | input | 3 | Message type: 0 doorbell, 1 critical doorbell |
| msg_bcast_i | input | 1 | Broadcast send |
| msg_tag_i | input | 8 | Destination tag of a send |
| core_id_i | input | 8 | This core's identifier |
| pending_o | output | 12 | Registered pending flags, bit k = code k |
| take_o | output | 1 | Registered delivery strobe |
| code_o | output | 4 | Registered code of the delivered source |
| hard_req_o | output | 1 | Registered request: some flag is pending |

## Verification
A set pulse or a message shows on `pending_o` and `hard_req_o` one clock edge after it is driven. The delivery it causes shows on `take_o` and `code_o` one edge after that, and an edge-type flag clears at that same second edge. The bench drives inputs on the falling edge, steps whole cycles, and samples on the falling edge after the edge where each result is due. For level sources and an uncleared decrementer, it samples over several consecutive cycles to confirm that delivery repeats.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int N_SRC  = 12;
  localparam int CODE_W = 4;

  localparam int SRC_RST   = 0;
  localparam int SRC_MCHK  = 1;
  localparam int SRC_CEXT  = 2;
  localparam int SRC_WDOG  = 3;
  localparam int SRC_CDB   = 4;
  localparam int SRC_FIT   = 5;
  localparam int SRC_PIT   = 6;
  localparam int SRC_DECR  = 7;
  localparam int SRC_EXT   = 8;
  localparam int SRC_DB    = 9;
  localparam int SRC_PERF  = 10;
  localparam int SRC_THERM = 11;

  // sources whose flag follows an input line instead of a pulse
  localparam logic [N_SRC-1:0] LEVEL_MASK = (N_SRC'(1) << SRC_CEXT) | (N_SRC'(1) << SRC_EXT);

  localparam int DB_TYPE_NORM = 0;
  localparam int DB_TYPE_CRIT = 1;
endpackage

// File: rtl/irq_dbell_dec.sv
module irq_dbell_dec #(
  parameter int TAG_W  = 8,
  parameter int TYPE_W = 3
) (
  input  logic              valid,
  input  logic              is_clr,
  input  logic [TYPE_W-1:0] mtype,
  input  logic              bcast,
  input  logic [TAG_W-1:0]  tag,
  input  logic [TAG_W-1:0]  my_id,
  output logic              set_norm,
  output logic              set_crit,
  output logic              clr_norm,
  output logic              clr_crit
);
  import irq_arb_pkg::*;

  logic is_norm, is_crit, addressed;

  always_comb begin
    is_norm   = (mtype == TYPE_W'(DB_TYPE_NORM));
    is_crit   = (mtype == TYPE_W'(DB_TYPE_CRIT));
    addressed = bcast || (tag == my_id);
    set_norm  = valid && !is_clr && addressed && is_norm;
    set_crit  = valid && !is_clr && addressed && is_crit;
    clr_norm  = valid && is_clr && is_norm;
    clr_crit  = valid && is_clr && is_crit;
  end
endmodule

// File: rtl/irq_pend_store.sv
module irq_pend_store
  import irq_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_set,
  input  logic              deliver,
  input  logic [CODE_W-1:0] deliver_idx,
  input  logic              decr_cod,
  input  logic              db_set_norm,
  input  logic              db_set_crit,
  input  logic              db_clr_norm,
  input  logic              db_clr_crit,
  output logic [N_SRC-1:0]  pend_d,
  output logic [N_SRC-1:0]  pend_q
);
  for (genvar k = 0; k < N_SRC; k++) begin : g_bit
    if (LEVEL_MASK[k]) begin : g_level
      assign pend_d[k] = src_set[k];
    end else begin : g_edge
      logic hit, cod, mset, mclr;
      assign hit = deliver && (deliver_idx == CODE_W'(k));
      assign cod = (k == SRC_DECR) ? decr_cod : 1'b1;
      if (k == SRC_DB) begin : g_db
        assign mset = db_set_norm;
        assign mclr = db_clr_norm;
      end else if (k == SRC_CDB) begin : g_cdb
        assign mset = db_set_crit;
        assign mclr = db_clr_crit;
      end else begin : g_nodb
        assign mset = 1'b0;
        assign mclr = 1'b0;
      end
      assign pend_d[k] = (pend_q[k] & ~(hit & cod) & ~mclr) | src_set[k] | mset;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_arb_pkg::*;
(
  input  logic [N_SRC-1:0]  pend,
  input  logic              crit_en,
  input  logic              ext_en,
  output logic              any,
  output logic [CODE_W-1:0] idx
);
  logic [N_SRC-1:0] elig;

  for (genvar k = 0; k < N_SRC; k++) begin : g_gate
    if (k < SRC_CEXT) begin : g_nmi
      assign elig[k] = pend[k];
    end else if (k == SRC_CEXT) begin : g_crit
      assign elig[k] = pend[k] & crit_en;
    end else begin : g_ext
      assign elig[k] = pend[k] & ext_en;
    end
  end

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (elig[k]) begin
        any = 1'b1;
        idx = CODE_W'(k);
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int TYPE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_set_i,
  input  logic              crit_en_i,
  input  logic              ext_en_i,
  input  logic              decr_cod_i,
  input  logic              msg_valid_i,
  input  logic              msg_clr_i,
  input  logic [TYPE_W-1:0] msg_type_i,
  input  logic              msg_bcast_i,
  input  logic [TAG_W-1:0]  msg_tag_i,
  input  logic [TAG_W-1:0]  core_id_i,
  output logic [N_SRC-1:0]  pending_o,
  output logic              take_o,
  output logic [CODE_W-1:0] code_o,
  output logic              hard_req_o
);
  logic              db_sn, db_sc, db_cn, db_cc;
  logic [N_SRC-1:0]  pend_d, pend_q;
  logic              sel_any;
  logic [CODE_W-1:0] sel_idx;
  logic              take_q, hard_q;
  logic [CODE_W-1:0] code_q;

  irq_dbell_dec #(.TAG_W(TAG_W), .TYPE_W(TYPE_W)) u_dec (
    .valid    (msg_valid_i),
    .is_clr   (msg_clr_i),
    .mtype    (msg_type_i),
    .bcast    (msg_bcast_i),
    .tag      (msg_tag_i),
    .my_id    (core_id_i),
    .set_norm (db_sn),
    .set_crit (db_sc),
    .clr_norm (db_cn),
    .clr_crit (db_cc)
  );

  irq_prio_sel u_sel (
    .pend    (pend_q),
    .crit_en (crit_en_i),
    .ext_en  (ext_en_i),
    .any     (sel_any),
    .idx     (sel_idx)
  );

  irq_pend_store u_store (
    .clk         (clk),
    .rst         (rst),
    .src_set     (src_set_i),
    .deliver     (sel_any),
    .deliver_idx (sel_idx),
    .decr_cod    (decr_cod_i),
    .db_set_norm (db_sn),
    .db_set_crit (db_sc),
    .db_clr_norm (db_cn),
    .db_clr_crit (db_cc),
    .pend_d      (pend_d),
    .pend_q      (pend_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_q <= 1'b0;
      code_q <= '0;
      hard_q <= 1'b0;
    end else begin
      take_q <= sel_any;
      code_q <= sel_any ? sel_idx : '0;
      hard_q <= |pend_d;
    end
  end

  assign pending_o  = pend_q;
  assign take_o     = take_q;
  assign code_o     = code_q;
  assign hard_req_o = hard_q;
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk
  import irq_arb_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [N_SRC-1:0]  src_set_i,
  input logic              crit_en_i,
  input logic              decr_cod_i,
  input logic [N_SRC-1:0]  pending_o,
  input logic              take_o,
  input logic [CODE_W-1:0] code_o,
  input logic              hard_req_o
);
  AST_RESET_FIRST: assert property (@(posedge clk) disable iff (rst)
    pending_o[SRC_RST] |=> (take_o && code_o == CODE_W'(SRC_RST))); // R1

  AST_CRIT_WHEN_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (pending_o[SRC_CEXT] && crit_en_i && !pending_o[SRC_RST] && !pending_o[SRC_MCHK])
    |=> (take_o && code_o == CODE_W'(SRC_CEXT))); // R2

  AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (code_o < CODE_W'(N_SRC))); // R4

  AST_EDGE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (take_o && code_o == CODE_W'(SRC_WDOG) && !$past(src_set_i[SRC_WDOG]))
    |-> !pending_o[SRC_WDOG]); // R5

  AST_LEVEL_KEPT: assert property (@(posedge clk) disable iff (rst)
    (take_o && code_o == CODE_W'(SRC_EXT) && $past(src_set_i[SRC_EXT]))
    |-> pending_o[SRC_EXT]); // R6

  AST_DECR_KEPT: assert property (@(posedge clk) disable iff (rst)
    (take_o && code_o == CODE_W'(SRC_DECR) && !$past(decr_cod_i))
    |-> pending_o[SRC_DECR]); // R7

  AST_REQ_WHILE_PENDING: assert property (@(posedge clk) disable iff (rst)
    (pending_o != '0) |-> hard_req_o); // R8
endmodule

bind irq_arbiter irq_arb_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .src_set_i  (src_set_i),
  .crit_en_i  (crit_en_i),
  .decr_cod_i (decr_cod_i),
  .pending_o  (pending_o),
  .take_o     (take_o),
  .code_o     (code_o),
  .hard_req_o (hard_req_o)
);

// File: tb/tb_irq_arbiter.sv
`timescale 1ns/1ps
module tb_irq_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] src_set_i = '0;
  logic        crit_en_i = 1'b0, ext_en_i = 1'b0, decr_cod_i = 1'b0;
  logic        msg_valid_i = 1'b0, msg_clr_i = 1'b0, msg_bcast_i = 1'b0;
  logic [2:0]  msg_type_i = '0;
  logic [7:0]  msg_tag_i = '0, core_id_i = 8'h5A;
  logic [11:0] pending_o;
  logic        take_o, hard_req_o;
  logic [3:0]  code_o;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_arbiter dut (
    .clk(clk), .rst(rst), .src_set_i(src_set_i), .crit_en_i(crit_en_i),
    .ext_en_i(ext_en_i), .decr_cod_i(decr_cod_i), .msg_valid_i(msg_valid_i),
    .msg_clr_i(msg_clr_i), .msg_type_i(msg_type_i), .msg_bcast_i(msg_bcast_i),
    .msg_tag_i(msg_tag_i), .core_id_i(core_id_i), .pending_o(pending_o),
    .take_o(take_o), .code_o(code_o), .hard_req_o(hard_req_o)
  );

  // {set[11:0], crit_en, ext_en, exp_take, exp_code[3:0]}
  localparam logic [18:0] VEC [14] = '{
    {12'hFFF, 1'b0, 1'b0, 1'b1, 4'd0},
    {12'hFFE, 1'b0, 1'b0, 1'b1, 4'd1},
    {12'hFFC, 1'b1, 1'b0, 1'b1, 4'd2},
    {12'hFFC, 1'b0, 1'b0, 1'b0, 4'd0},
    {12'hFF8, 1'b0, 1'b1, 1'b1, 4'd3},
    {12'hFF0, 1'b0, 1'b1, 1'b1, 4'd4},
    {12'hFE0, 1'b0, 1'b1, 1'b1, 4'd5},
    {12'hFC0, 1'b0, 1'b1, 1'b1, 4'd6},
    {12'hF80, 1'b0, 1'b1, 1'b1, 4'd7},
    {12'hF00, 1'b0, 1'b1, 1'b1, 4'd8},
    {12'hE00, 1'b0, 1'b1, 1'b1, 4'd9},
    {12'hC00, 1'b0, 1'b1, 1'b1, 4'd10},
    {12'h800, 1'b1, 1'b0, 1'b0, 4'd0},
    {12'h004, 1'b0, 1'b1, 1'b0, 4'd0}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    rst = 1'b0;
  endtask

  task automatic send(input bit clr, input logic [2:0] t, input bit bc, input logic [7:0] tg);
    msg_valid_i = 1'b1; msg_clr_i = clr; msg_type_i = t; msg_bcast_i = bc; msg_tag_i = tg;
    tick();
    msg_valid_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick();
    rst = 1'b0;
    // R12 reset state
    chk(pending_o == 0 && !take_o && code_o == 0 && !hard_req_o, "R12 reset state",
        {pending_o, take_o, code_o, hard_req_o}, 0);

    // table: priority and gating (R1 R2 R3 R4)
    for (int i = 0; i < 14; i++) begin
      logic [18:0] v;
      v = VEC[i];
      do_reset();
      crit_en_i = v[6]; ext_en_i = v[5];
      src_set_i = v[18:7];
      tick();
      src_set_i = '0;
      tick();
      chk(take_o == v[4] && code_o == v[3:0], "R1 R2 R3 R4 priority vector",
          {take_o, code_o}, {v[4], v[3:0]});
    end

    // R5 edge source cleared on delivery, R8 request drops
    do_reset();
    crit_en_i = 1'b0; ext_en_i = 1'b1;
    src_set_i = 12'h008; tick(); src_set_i = '0;
    chk(hard_req_o && pending_o == 12'h008, "R8 request raised", {hard_req_o, pending_o}, 13'h1008);
    tick();
    chk(take_o && code_o == 3 && pending_o == 0, "R5 watchdog cleared", {take_o, code_o, pending_o}, {1'b1, 4'd3, 12'h000});
    chk(!hard_req_o, "R8 request dropped", hard_req_o, 0);
    tick();
    chk(!take_o, "R4 no take when idle", take_o, 0);

    // R6 level source external held
    do_reset();
    src_set_i = 12'h100; tick();
    tick();
    chk(take_o && code_o == 8 && pending_o[8], "R6 external kept after take", {take_o, code_o, pending_o[8]}, {1'b1, 4'd8, 1'b1});
    tick();
    chk(take_o && code_o == 8, "R6 external retaken", {take_o, code_o}, {1'b1, 4'd8});
    src_set_i = '0; tick();
    chk(pending_o == 0, "R6 external follows line", pending_o, 0);
    tick();
    chk(!take_o, "R6 no take after drop", take_o, 0);

    // R6 critical external level with crit_en only
    do_reset();
    crit_en_i = 1'b1; ext_en_i = 1'b0;
    src_set_i = 12'h004; tick(); tick();
    chk(take_o && code_o == 2 && pending_o[2], "R6 critical external kept", {take_o, code_o, pending_o[2]}, {1'b1, 4'd2, 1'b1});
    src_set_i = '0; crit_en_i = 1'b0;

    // R7 decrementer clear-on-delivery configuration
    do_reset();
    ext_en_i = 1'b1; decr_cod_i = 1'b0;
    src_set_i = 12'h080; tick(); src_set_i = '0;
    tick();
    chk(take_o && code_o == 7 && pending_o[7], "R7 decrementer kept", {take_o, code_o, pending_o[7]}, {1'b1, 4'd7, 1'b1});
    tick();
    chk(take_o && code_o == 7, "R7 decrementer retaken", {take_o, code_o}, {1'b1, 4'd7});
    decr_cod_i = 1'b1; tick();
    chk(take_o && code_o == 7 && pending_o == 0, "R7 decrementer cleared", {take_o, code_o, pending_o}, {1'b1, 4'd7, 12'h000});
    chk(!hard_req_o, "R8 request dropped after decrementer", hard_req_o, 0);
    decr_cod_i = 1'b0;

    // doorbell messages, delivery masked
    do_reset();
    ext_en_i = 1'b0;
    send(1'b0, 3'd0, 1'b0, 8'h5A);
    chk(pending_o == 12'h200, "R10 tag match send", pending_o, 12'h200);
    send(1'b0, 3'd1, 1'b0, 8'h33);
    chk(pending_o == 12'h200, "R10 tag mismatch ignored", pending_o, 12'h200);
    send(1'b0, 3'd1, 1'b1, 8'h33);
    chk(pending_o == 12'h210, "R10 broadcast send", pending_o, 12'h210);
    send(1'b0, 3'd2, 1'b1, 8'h5A);
    chk(pending_o == 12'h210, "R9 unknown type send ignored", pending_o, 12'h210);
    send(1'b1, 3'd5, 1'b0, 8'h5A);
    chk(pending_o == 12'h210, "R9 unknown type clear ignored", pending_o, 12'h210);
    send(1'b1, 3'd1, 1'b0, 8'h00);
    chk(pending_o == 12'h200 && hard_req_o, "R11 critical doorbell cleared", {pending_o, hard_req_o}, 13'h0401);
    send(1'b1, 3'd0, 1'b0, 8'hFF);
    chk(pending_o == 0 && !hard_req_o, "R11 doorbell cleared", {pending_o, hard_req_o}, 0);

    // R12 reset mid-run
    src_set_i = 12'hFFF; tick(); src_set_i = '0;
    do_reset();
    chk(pending_o == 0 && !take_o && !hard_req_o, "R12 reset clears state", {pending_o, take_o, hard_req_o}, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule